// File: doc/BRIEF.md
# Pulse-Coded Packet Receiver

This block collects a fixed-length command packet that a host sends one bit at a time by changing two lines in a port byte it writes. Only a change of the two-bit line level counts: a clear level restarts reception and empties the packet store. A one level records a set bit at the current position. A zero level records a cleared bit. The idle level records nothing. Writes that repeat the level already seen are dropped.

Bits fill the packet store starting at the least significant end. When every bit position has been filled, the host sends one more zero level. This stop level raises a single-cycle valid strobe, and the assembled packet is then held unchanged until the next clear level. What the packet's contents mean is left to the logic that consumes it.

The written byte passes through a level decoder that keeps the last seen line level. A bit counter follows it, tracking the fill position, the full state and the delivered state. The packet store uses per-byte clock enables. Reset is asynchronous and active low, and its release is synchronized to the clock.

Top module: `pcr_receiver`

## Requirements
- R1: The line level is taken from bits [LINE_LSB+1:LINE_LSB] of the written byte (bits 5:4 by default). No other bit of the byte has any effect.
- R2: A write whose line level equals the last latched level changes nothing: neither the count nor the packet. After reset the latched level is 3 (idle).
- R3: A level change to 0 sets the bit count to 0 and zeroes every bit of the packet.
- R4: A level change to 1 with a count below PKT_BITS sets packet bit `count`, then increments the count.
- R5: A level change to 2 with a count below PKT_BITS increments the count and leaves that packet bit 0.
- R6: Packet bit n sits in byte n/8 at bit position n%8, so it is `pkt_data[n]`. Byte k is `pkt_data[8k+7:8k]`.
- R7: A level change to 2 while the count equals PKT_BITS raises `pkt_valid` for exactly one clock, starting the cycle after the write, and moves the count to PKT_BITS+1.
- R8: While the count is PKT_BITS or more, levels 1 and 2 record no bit. Only the case in R7 raises `pkt_valid`. The count never exceeds PKT_BITS+1.
- R9: A level change to 3 (idle) records no bit and does not move the count. It only updates the latched level.
- R10: After delivery the packet holds its value until a level change to 0.
- R11: During and after reset, `pkt_valid` is 0 and `pkt_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port byte write strobe, one write per cycle |
| wr_data | input | DATA_W | Written port byte carrying the line level |
| pkt_data | output | PKT_BITS | Assembled packet, bit n at index n |
| pkt_valid | output | 1 | One-cycle packet delivery strobe |

## Verification
The bench builds the receiver with PKT_BITS set to 8. At that size the full payload space of 256 packets can be swept, and every sweep drives the counter through its full state and its delivered state. Repeated levels, junk in the unused byte bits, extra levels after the store is full, and clear levels in mid-packet are mixed into the sweep, so each stop strobe lands on an exactly predictable cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [1:0] {
    LN_CLEAR = 2'd0,
    LN_ONE   = 2'd1,
    LN_ZERO  = 2'd2,
    LN_IDLE  = 2'd3
  } line_code_e;

  typedef struct packed {
    logic clear;
    logic one;
    logic zero;
  } line_evt_t;

endpackage

// File: rtl/pcr_reset_sync.sv
module pcr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcr_line_decoder.sv
module pcr_line_decoder
  import pcr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LINE_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output line_evt_t         evt,
  output logic              dup
);
  line_code_e line;
  line_code_e prev_q;
  line_code_e prev_d;
  logic       changed;
  logic       unused_bits;

  assign line        = line_code_e'(wr_data[LINE_LSB+1:LINE_LSB]);
  assign unused_bits = ^wr_data;

  always_comb begin
    changed   = wr_en && (line != prev_q);
    dup       = wr_en && (line == prev_q);
    evt.clear = changed && (line == LN_CLEAR);
    evt.one   = changed && (line == LN_ONE);
    evt.zero  = changed && (line == LN_ZERO);
    prev_d    = wr_en ? line : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= LN_IDLE;
    else if (wr_en) prev_q <= prev_d;
  end

  // R9
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.clear, evt.one, evt.zero}));
endmodule

// File: rtl/pcr_bit_counter.sv
module pcr_bit_counter #(
  parameter int PKT_BITS = 128,
  localparam int CNT_W   = $clog2(PKT_BITS + 2),
  localparam int IDX_W   = $clog2(PKT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             one,
  input  logic             zero,
  output logic [CNT_W-1:0] count,
  output logic             set_en,
  output logic [IDX_W-1:0] set_idx,
  output logic             pkt_valid
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PKT_BITS);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(PKT_BITS + 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             filling;
  logic             deliver;
  logic             valid_q;

  always_comb begin
    filling  = count_q < FULL;
    deliver  = zero && (count_q == FULL);
    set_en   = one && filling;
    set_idx  = count_q[IDX_W-1:0];
    count_en = clear || ((one || zero) && filling) || deliver;
    if (clear)        count_d = '0;
    else if (deliver) count_d = DONE;
    else              count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= deliver;
  end

  assign count     = count_q;
  assign pkt_valid = valid_q;

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DONE);
  // R7
  valid_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> count_q == DONE);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/pcr_packet_buffer.sv
module pcr_packet_buffer #(
  parameter int PKT_BITS = 128,
  localparam int IDX_W   = $clog2(PKT_BITS),
  localparam int BYTES   = PKT_BITS / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  output logic [PKT_BITS-1:0] data
);
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic [7:0] mask;
    logic       hit;
    logic       byte_en;

    always_comb begin
      hit = set_en && ((set_idx >> 3) == IDX_W'(g));
      for (int b = 0; b < 8; b++) begin
        mask[b] = hit && (set_idx == IDX_W'(g * 8 + b));
      end
      byte_en = clear || hit;
      byte_d  = clear ? 8'h00 : (byte_q | mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'h00;
      else if (byte_en) byte_q <= byte_d;
    end

    assign data[g*8 +: 8] = byte_q;

    // R4
    set_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clear) |=> $countones(byte_q) <= $countones($past(byte_q)) + 1);
  end
endmodule

// File: rtl/pcr_receiver.sv
module pcr_receiver
  import pcr_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int DATA_W   = 8,
  parameter int LINE_LSB = 4,
  localparam int CNT_W   = $clog2(PKT_BITS + 2),
  localparam int IDX_W   = $clog2(PKT_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [PKT_BITS-1:0] pkt_data,
  output logic                pkt_valid
);
  logic             rst_i_n;
  line_evt_t        evt;
  logic             dup;
  logic [CNT_W-1:0] count;
  logic             set_en;
  logic [IDX_W-1:0] set_idx;

  initial begin
    if (PKT_BITS % 8 != 0 || PKT_BITS < 8)
      $error("PKT_BITS must be a positive multiple of 8");
    if (LINE_LSB + 2 > DATA_W)
      $error("line field outside the port byte");
  end

  pcr_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pcr_line_decoder #(.DATA_W(DATA_W), .LINE_LSB(LINE_LSB)) u_dec (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt     (evt),
    .dup     (dup)
  );

  pcr_bit_counter #(.PKT_BITS(PKT_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (evt.clear),
    .one       (evt.one),
    .zero      (evt.zero),
    .count     (count),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .pkt_valid (pkt_valid)
  );

  pcr_packet_buffer #(.PKT_BITS(PKT_BITS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (evt.clear),
    .set_en  (set_en),
    .set_idx (set_idx),
    .data    (pkt_data)
  );

  // R2
  dup_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    dup |=> $stable(count) && $stable(pkt_data));
  // R3
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt.clear |=> (count == '0) && (pkt_data == '0));
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (count >= CNT_W'(PKT_BITS) && !evt.clear) |=> $stable(pkt_data));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && !evt.clear && !evt.one && !evt.zero) |=> $stable(count));
endmodule

// File: tb/tb_pcr_receiver.sv
module tb_pcr_receiver;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_data;
  logic [N-1:0] pkt_data;
  logic         pkt_valid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pcr_receiver #(.PKT_BITS(N), .DATA_W(8), .LINE_LSB(4)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pkt_data  (pkt_data),
    .pkt_valid (pkt_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One port write; line level in bits 5:4, junk elsewhere (R1).
  task automatic put(input logic [1:0] code, input logic [5:0] junk, input logic exp_valid,
                     input string req);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {junk[5:4], code, junk[3:0]};
    @(negedge clk);
    wr_en = 1'b0;
    check(req, int'(pkt_valid), int'(exp_valid));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R11
    check("R11 valid in reset", int'(pkt_valid), 0);
    check("R11 data in reset", int'(pkt_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 valid after reset", int'(pkt_valid), 0);
    check("R11 data after reset", int'(pkt_data), 0);

    // R2: latched level is idle after reset, so an idle write is a repeat
    put(2'd3, 6'h2A, 1'b0, "R2 idle repeat after reset");
    check("R2 data unchanged", int'(pkt_data), 0);

    // Sweep every payload
    for (int p = 0; p < (1 << N); p++) begin
      put(2'd3, 6'(p), 1'b0, "R9 idle before clear");
      put(2'd0, 6'(p + 1), 1'b0, "R3 clear");
      check("R3 data cleared", int'(pkt_data), 0);
      for (int i = 0; i < N; i++) begin
        logic [1:0] c;
        c = p[i] ? 2'd1 : 2'd2;
        put(c, 6'(p ^ (i * 7)), 1'b0, p[i] ? "R4 one bit" : "R5 zero bit");
        if ((p % 3) == 1) put(c, 6'(~p), 1'b0, "R2 repeated level");
        put(2'd3, 6'(i + p), 1'b0, "R9 idle between bits");
      end
      // R7 stop level on a full count
      put(2'd2, 6'(p), 1'b1, "R7 stop delivers");
      // R6 R4 R5 packing
      check("R6 packet contents", int'(pkt_data), p);
      @(negedge clk);
      check("R7 valid one cycle", int'(pkt_valid), 0);
      // R8 R10 after delivery
      put(2'd3, 6'h15, 1'b0, "R8 idle after stop");
      put(2'd1, 6'h3F, 1'b0, "R8 one after stop");
      put(2'd2, 6'h00, 1'b0, "R8 second stop ignored");
      check("R10 packet held", int'(pkt_data), p);
    end

    // R8: extra one on a full count is dropped, stop still delivers
    put(2'd0, 6'h00, 1'b0, "R3 clear");
    for (int i = 0; i < N; i++) begin
      put(2'd2, 6'h11, 1'b0, "R5 zero bit");
      put(2'd3, 6'h22, 1'b0, "R9 idle");
    end
    put(2'd1, 6'h33, 1'b0, "R8 one on full count");
    put(2'd3, 6'h00, 1'b0, "R9 idle");
    check("R8 extra one not recorded", int'(pkt_data), 0);
    put(2'd2, 6'h00, 1'b1, "R7 stop after extra one");
    check("R8 data after stop", int'(pkt_data), 0);

    // R3: clear in mid-packet discards earlier bits
    put(2'd0, 6'h00, 1'b0, "R3 clear");
    put(2'd1, 6'h00, 1'b0, "R4 one bit");
    put(2'd3, 6'h00, 1'b0, "R9 idle");
    put(2'd1, 6'h00, 1'b0, "R4 one bit");
    check("R4 partial packet", int'(pkt_data), 3);
    put(2'd0, 6'h3F, 1'b0, "R3 mid clear");
    check("R3 mid clear zeroes", int'(pkt_data), 0);
    for (int i = 0; i < N; i++) begin
      put((i == N - 1) ? 2'd1 : 2'd2, 6'h0C, 1'b0, "R5 bits after clear");
      put(2'd3, 6'h30, 1'b0, "R9 idle");
    end
    put(2'd2, 6'h00, 1'b1, "R7 stop after mid clear");
    check("R6 msb only", int'(pkt_data), 1 << (N - 1));
    put(2'd0, 6'h00, 1'b0, "R3 clear after delivery");
    check("R10 released by clear", int'(pkt_data), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule